// File: doc/BRIEF.md
# Horizontal sync rate counter

This block measures the line rate of a synchronised horizontal sync input. It counts rising edges of `hsync` inside a gate that stays open for `GATE_TICKS` ticks of an external timebase, then stays shut until `PERIOD_TICKS` ticks have gone by since it opened. With an 8 us tick the defaults give a 32 ms gate that repeats every 32.768 ms. As a result the 12-bit count reads directly as kilohertz in its upper seven bits and as 1/32 kHz steps in its lower five bits.

The result is read as two bytes. When the gate shuts, the upper seven count bits and an overflow flag go straight into the high byte. The lower five bits go into a hidden holding buffer. A read strobe on the high byte copies that buffer into the low byte, so software reads the high byte first and the low byte second, and always gets a matched pair. The overflow flag is set the moment a window sees more than 4095 edges, which means a rate above 128 kHz. A `no_pulse` flag reports a window that saw no edges at all, for display power-state detection.

A two-state machine times the gate. `S_OPEN` counts edges. The transition *gate close* (the last open tick) publishes the result and moves to `S_CLOSED`. `S_CLOSED` ignores edges. The transition *period end* (the last tick of the period) clears the running count and returns to `S_OPEN`. Reset enters `S_OPEN` with the tick count at zero.

Top module: `hsync_rate_counter`

## Requirements
- R1: After reset `hi_data` and `lo_data` are 0 and `no_pulse` is 1.
- R2: A window's count is the number of rising edges of `hsync` seen at the `GATE_TICKS` clock edges that carry a tick while the gate is open, including the edge of the closing tick. Edges while the gate is shut are not counted.
- R3: At gate close, `hi_data[6:0]` takes count bits 11:5. These bits are visible from the cycle after the closing tick and change at no other time.
- R4: Count bits 4:0 go to a hidden buffer. `lo_data[4:0]` loads the buffer only at a clock edge where `rd_hi` is 1, and otherwise holds its value.
- R5: `lo_data[7:5]` always reads 0.
- R6: `hi_data[7]` becomes 1 in the cycle after the 4096th rising edge of a window. The count then stays at 4095, so that window publishes `hi_data` = 0xFF and a buffer value of 0x1F.
- R7: `hi_data[7]` is reloaded at every gate close. A window with 4095 or fewer edges publishes it as 0.
- R8: At period end the running count restarts from zero, so no result carries edges from an earlier window.
- R9: If a result is published between a high read and the following low read, `lo_data` keeps the bits that belong to the earlier high read. If `rd_hi` falls on the closing tick itself, `lo_data` takes the previous buffer.
- R10: `no_pulse` is 1 exactly when the last published count was 0 and `hi_data[7]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, already synchronised to `clk` |
| gate_tick | input | 1 | One-cycle timebase tick that times the gate |
| rd_hi | input | 1 | Read strobe for the high byte; loads the low byte from the buffer |
| hi_data | output | 8 | Overflow flag in bit 7, count bits 11:5 in bits 6:0 |
| lo_data | output | 8 | Count bits 4:0 in bits 4:0, zeros above |
| no_pulse | output | 1 | The last window saw no edges |

## Verification
A high-byte read can land in the same cycle as the gate-close publish. In that case the low byte must take the old buffer while the buffer takes the new value. The bench waits until its model reaches the last open tick and raises `rd_hi` on exactly that cycle. It then checks that `lo_data` shows the bits of the earlier window and that a second read brings out the new ones. The overflow setting and the gate-close reload of the flag meet in a window that passes 4095 edges. There the flag is checked one cycle after the 4096th edge, again at the close, and again after the next, quieter window.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
    typedef enum logic [0:0] {
        S_OPEN   = 1'b0,
        S_CLOSED = 1'b1
    } gate_state_t;
endpackage

// File: rtl/hsr_edge.sv
module hsr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/hsr_window_fsm.sv
module hsr_window_fsm
    import hsr_pkg::*;
#(
    parameter int GATE_TICKS   = 4000,
    parameter int PERIOD_TICKS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic gate_open,
    output logic publish,
    output logic restart
);
    localparam int TC_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [TC_W-1:0] LAST_OPEN = TC_W'(GATE_TICKS - 1);
    localparam logic [TC_W-1:0] LAST_TICK = TC_W'(PERIOD_TICKS - 1);

    gate_state_t     state_q, state_d;
    logic [TC_W-1:0] tc_q;

    // state register and tick position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_OPEN;
            tc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (tick) tc_q <= restart ? '0 : tc_q + TC_W'(1);
        end
    end

    // transitions: gate close (S_OPEN -> S_CLOSED), period end (S_CLOSED -> S_OPEN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPEN:   if (publish) state_d = S_CLOSED;
            S_CLOSED: if (restart) state_d = S_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        gate_open = 1'b0;
        publish   = 1'b0;
        restart   = 1'b0;
        unique case (state_q)
            S_OPEN: begin
                gate_open = 1'b1;
                publish   = tick && (tc_q == LAST_OPEN);
            end
            S_CLOSED: begin
                restart   = tick && (tc_q == LAST_TICK);
            end
        endcase
    end
endmodule

// File: rtl/hsr_pulse_counter.sv
module hsr_pulse_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             ovf_nxt,
    output logic             ovf_event
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic ovf_q;

    assign ovf_event = count_en && (cnt_q == CNT_MAX);
    assign cnt_nxt   = (count_en && (cnt_q != CNT_MAX)) ? cnt_q + CNT_W'(1) : cnt_q;
    assign ovf_nxt   = ovf_q | ovf_event;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            ovf_q <= ovf_nxt;
        end
    end
endmodule

// File: rtl/hsr_read_regs.sv
module hsr_read_regs #(
    parameter int CNT_W  = 12,
    parameter int LO_W   = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              publish,
    input  logic [CNT_W-1:0]  pub_cnt,
    input  logic              pub_ovf,
    input  logic              ovf_event,
    input  logic              rd_hi,
    output logic [CNT_W-LO_W:0] hi_data,
    output logic [DATA_W-1:0] lo_data,
    output logic              no_pulse
);
    localparam int HI_W = CNT_W - LO_W;

    logic            hi_ovf_q;
    logic [HI_W-1:0] hi_cnt_q;
    logic [LO_W-1:0] lo_buf_q;
    logic [LO_W-1:0] lo_q;
    logic            zero_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_ovf_q <= 1'b0;
            hi_cnt_q <= '0;
            lo_buf_q <= '0;
            lo_q     <= '0;
            zero_q   <= 1'b1;
        end else begin
            if (publish) begin
                hi_ovf_q <= pub_ovf;
                hi_cnt_q <= pub_cnt[CNT_W-1:LO_W];
                lo_buf_q <= pub_cnt[LO_W-1:0];
                zero_q   <= (pub_cnt == '0);
            end else if (ovf_event) begin
                hi_ovf_q <= 1'b1;
            end
            if (rd_hi) lo_q <= lo_buf_q;
        end
    end

    assign hi_data  = {hi_ovf_q, hi_cnt_q};
    assign lo_data  = {{(DATA_W-LO_W){1'b0}}, lo_q};
    assign no_pulse = zero_q & ~hi_ovf_q;
endmodule

// File: rtl/hsync_rate_counter.sv
module hsync_rate_counter #(
    parameter int CNT_W        = 12,
    parameter int LO_W         = 5,
    parameter int DATA_W       = 8,
    parameter int GATE_TICKS   = 4000,
    parameter int PERIOD_TICKS = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsync,
    input  logic                 gate_tick,
    input  logic                 rd_hi,
    output logic [CNT_W-LO_W:0]  hi_data,
    output logic [DATA_W-1:0]    lo_data,
    output logic                 no_pulse
);
    localparam int HI_W = CNT_W - LO_W;

    logic             hs_rise;
    logic             gate_open;
    logic             publish;
    logic             restart;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             ovf_nxt;
    logic             ovf_event;

    hsr_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (hsync),
        .rise  (hs_rise)
    );

    hsr_window_fsm #(
        .GATE_TICKS   (GATE_TICKS),
        .PERIOD_TICKS (PERIOD_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (gate_tick),
        .gate_open (gate_open),
        .publish   (publish),
        .restart   (restart)
    );

    hsr_pulse_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (gate_open & hs_rise),
        .clear     (restart),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt),
        .ovf_nxt   (ovf_nxt),
        .ovf_event (ovf_event)
    );

    hsr_read_regs #(
        .CNT_W  (CNT_W),
        .LO_W   (LO_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .publish   (publish),
        .pub_cnt   (cnt_nxt),
        .pub_ovf   (ovf_nxt),
        .ovf_event (ovf_event),
        .rd_hi     (rd_hi),
        .hi_data   (hi_data),
        .lo_data   (lo_data),
        .no_pulse  (no_pulse)
    );
endmodule

// File: rtl/hsync_rate_counter_chk.sv
module hsync_rate_counter_chk #(
    parameter int CNT_W  = 12,
    parameter int LO_W   = 5,
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_hi,
    input logic [CNT_W-LO_W:0] hi_data,
    input logic [DATA_W-1:0]   lo_data,
    input logic                no_pulse,
    input logic                gate_open,
    input logic                publish,
    input logic                restart,
    input logic                ovf_event,
    input logic [CNT_W-1:0]    cnt_q
);
    localparam int HI_W = CNT_W - LO_W;

    p_gate_phases_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(publish && restart));

    p_closed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !restart) |=> $stable(cnt_q));

    p_hi_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!publish && !ovf_event) |=> $stable(hi_data));

    p_lo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hi |=> $stable(lo_data));

    p_lo_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_data[DATA_W-1:LO_W] == '0);

    p_ovf_immediate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_event |=> hi_data[HI_W]);

    p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    p_no_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        no_pulse |-> (hi_data == '0));
endmodule

bind hsync_rate_counter hsync_rate_counter_chk #(
    .CNT_W  (CNT_W),
    .LO_W   (LO_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_hi     (rd_hi),
    .hi_data   (hi_data),
    .lo_data   (lo_data),
    .no_pulse  (no_pulse),
    .gate_open (gate_open),
    .publish   (publish),
    .restart   (restart),
    .ovf_event (ovf_event),
    .cnt_q     (cnt_q)
);

// File: tb/hsync_rate_counter_tb.sv
module hsync_rate_counter_tb;
    localparam int G = 9000;
    localparam int P = 9216;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic       gate_tick = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] hi_data;
    logic [7:0] lo_data;
    logic       no_pulse;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hsync_rate_counter #(
        .GATE_TICKS   (G),
        .PERIOD_TICKS (P)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .gate_tick (gate_tick),
        .rd_hi     (rd_hi),
        .hi_data   (hi_data),
        .lo_data   (lo_data),
        .no_pulse  (no_pulse)
    );

    // behavioural reference
    int m_open, m_tc, m_cnt, m_ovr, m_hi, m_buf, m_lo, m_zero, m_prev;

    always @(posedge clk) begin
        int rise, n_cnt, n_ovr, n_hi, n_buf, n_lo, n_zero;
        if (!rst_n) begin
            m_open = 1; m_tc = 0; m_cnt = 0; m_ovr = 0;
            m_hi = 0; m_buf = 0; m_lo = 0; m_zero = 1; m_prev = 0;
        end else begin
            rise = (hsync && !m_prev) ? 1 : 0;
            m_prev = hsync;
            n_cnt = m_cnt; n_ovr = m_ovr; n_hi = m_hi; n_buf = m_buf;
            n_lo = m_lo; n_zero = m_zero;
            if (m_open && rise) begin
                if (m_cnt == 4095) begin
                    n_ovr = 1;
                    n_hi = n_hi | 128;
                end else begin
                    n_cnt = m_cnt + 1;
                end
            end
            if (rd_hi) n_lo = m_buf;
            if (gate_tick) begin
                if (m_open) begin
                    if (m_tc == G - 1) begin
                        n_hi = n_ovr * 128 + n_cnt / 32;
                        n_buf = n_cnt % 32;
                        n_zero = (n_cnt == 0) ? 1 : 0;
                        m_open = 0;
                    end
                    m_tc = m_tc + 1;
                end else if (m_tc == P - 1) begin
                    m_tc = 0;
                    m_open = 1;
                    n_cnt = 0;
                    n_ovr = 0;
                end else begin
                    m_tc = m_tc + 1;
                end
            end
            m_cnt = n_cnt; m_ovr = n_ovr; m_hi = n_hi; m_buf = n_buf;
            m_lo = n_lo; m_zero = n_zero;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every cycle
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            chk("R3 hi[6:0] vs model", int'(hi_data[6:0]), m_hi % 128);
            chk("R6 hi[7] vs model", int'(hi_data[7]), m_hi / 128);
            chk("R4 lo vs model", int'(lo_data), m_lo);
            chk("R10 no_pulse vs model", int'(no_pulse), (m_zero && m_hi < 128) ? 1 : 0);
        end
    end

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            hsync = 1'b1;
            @(negedge clk);
            hsync = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic read_hi();
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_closed();
        while (m_open) @(negedge clk);
    endtask

    task automatic wait_open();
        while (!m_open) @(negedge clk);
    endtask

    task automatic wait_last_open();
        while (!(m_open && m_tc == G - 1)) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        gate_tick = 1'b1;
        started = 1;
        chk("R1 hi after reset", int'(hi_data), 0);
        chk("R1 lo after reset", int'(lo_data), 0);
        chk("R1 no_pulse after reset", int'(no_pulse), 1);

        // window 0: 1000 edges -> hi 0x1F, buffer 8
        pulses(1000);
        wait_closed();
        @(negedge clk);
        chk("R3 hi after 1000", int'(hi_data), 8'h1F);
        chk("R4 lo before read", int'(lo_data), 0);
        chk("R10 no_pulse with edges", int'(no_pulse), 0);
        pulses(50);
        read_hi();
        chk("R4 lo after read", int'(lo_data), 8);
        chk("R5 lo upper bits", int'(lo_data[7:5]), 0);

        // window 1: single edge on the closing tick is counted
        wait_open();
        wait_last_open();
        hsync = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
        chk("R2 closing-tick edge hi", int'(hi_data), 0);
        chk("R2 closing-tick edge no_pulse", int'(no_pulse), 0);
        read_hi();
        chk("R2 closing-tick edge lo", int'(lo_data), 1);

        // window 2: nothing
        wait_open();
        wait_closed();
        @(negedge clk);
        chk("R10 empty window no_pulse", int'(no_pulse), 1);
        chk("R10 empty window hi", int'(hi_data), 0);

        // window 3: exactly 4095 edges, no overflow
        wait_open();
        pulses(4095);
        wait_closed();
        @(negedge clk);
        chk("R7 4095 edges hi", int'(hi_data), 8'h7F);
        read_hi();
        chk("R7 4095 edges lo", int'(lo_data), 8'h1F);

        // window 4: overflow
        wait_open();
        pulses(4095);
        chk("R6 no flag at 4095", int'(hi_data[7]), 0);
        hsync = 1'b1;
        @(negedge clk);
        chk("R6 flag right after 4096th", int'(hi_data[7]), 1);
        hsync = 1'b0;
        @(negedge clk);
        pulses(300);
        wait_closed();
        @(negedge clk);
        chk("R6 saturated hi", int'(hi_data), 8'hFF);
        read_hi();
        chk("R6 saturated lo", int'(lo_data), 8'h1F);

        // window 5: 37 edges, flag reloaded, count restarted
        wait_open();
        pulses(37);
        wait_closed();
        @(negedge clk);
        chk("R7 flag cleared at close", int'(hi_data[7]), 0);
        chk("R8 count restarted", int'(hi_data), 1);
        chk("R9 lo keeps earlier pair", int'(lo_data), 8'h1F);
        read_hi();
        chk("R4 lo after read 37", int'(lo_data), 5);

        // window 6: read on the closing tick
        wait_open();
        pulses(3);
        wait_last_open();
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        chk("R9 same-cycle read hi", int'(hi_data), 0);
        chk("R9 same-cycle read lo", int'(lo_data), 5);
        @(negedge clk);
        read_hi();
        chk("R4 second read lo", int'(lo_data), 3);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule